// File: doc/BRIEF.md
# PCM Transmit Channel with Compact Sample Packing

This block is one transmit channel of an audio codec link controller. A processor (or a DMA engine elsewhere) writes 32-bit words into the channel's data port, where they are queued in a FIFO. The link serializer then walks through the audio slots of each frame. For every slot it asks the channel for a sample. The channel answers one cycle later with a 20-bit MSB-justified slot value, but only for slots that are enabled in its control word.

A control word sets the following:
- the channel enable;
- whether the FIFO is used at full depth or as a single holding word;
- the sample width;
- compact mode, in which each FIFO word carries two 16-bit samples;
- a per-slot enable mask for slots 3 through 9.

Live status flags report busy, empty, half-empty, full and a sticky underrun. Two interrupt lines, each gated by an enable, signal the half-empty level and the underrun. The underrun is cleared by a write-one pulse.

Clearing the channel enable leaves the FIFO contents and the compact half pointer in place. Dropping the interface enable empties the FIFO and restarts the compact pairing.

Top module: `pcm_tx_channel`

## Requirements
- R1: After reset the FIFO is empty. Busy, full, underrun, both interrupts and out_valid are low. Empty and half-empty are high, and the control and interrupt-enable words are zero.
- R2: A write on the data port is stored when the FIFO is not full in that cycle. A write while full is dropped, and the full flag stays high.
- R3: With the FIFO-enable bit (ctrl bit 1) clear, the capacity is one word. With it set, the capacity is DEPTH words (default 8).
- R4: Status flags are computed from the stored word count n and the capacity C:
  - empty is n==0;
  - full is n>=C;
  - half-empty is 2n<=C.
  The flags follow the stored contents whether or not the channel is enabled.
- R5: Busy is high when the channel is enabled and the FIFO holds a word, or when out_valid is high.
- R6: In non-compact mode each served slot takes one word and pops it. The size code in ctrl bits 3:2 sets how the word becomes a 20-bit value:
  - 0: 16-bit, giving {w[15:0],4'h0};
  - 1: 18-bit, giving {w[17:0],2'b0};
  - 2: 20-bit, giving w[19:0];
  - 3: 12-bit, giving {w[11:0],8'h0}.
- R7: In compact mode (ctrl bit 4) the first served slot takes {w[15:0],4'h0} and the next served slot takes {w[31:16],4'h0}. The word is popped after its upper half, so samples go out in ascending slot order across slots 3,4,6,7,8,9.
- R8: A request is served only when all of the following hold:
  - the interface and the channel (ctrl bit 0) are enabled;
  - slot_id is in 3..9;
  - the mask bit ctrl[5+slot_id-3] is set.
  Any other request produces no output and consumes nothing.
- R9: Serving a slot while the FIFO is empty outputs zero data and sets the sticky underrun flag. The set takes priority over a clear in the same cycle.
- R10: A pulse on uf_clr with no underrun event in that cycle clears the underrun flag.
- R11: irq_tx equals ie bit 0 AND half-empty AND channel enable. irq_uf equals ie bit 1 AND underrun.
- R12: Clearing the channel enable keeps the FIFO contents and the compact half position. Driving link_en low for one cycle empties the FIFO and restarts compact pairing at the lower half.
- R13: A served request raises out_valid, with its slot number and data, exactly one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_en | input | 1 | Interface enable; low flushes the FIFO |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 12 | Control word: [0] enable, [1] FIFO enable, [3:2] size, [4] compact, [11:5] slot 3..9 mask |
| ie_we | input | 1 | Interrupt-enable write strobe |
| ie_wdata | input | 2 | [0] half-empty interrupt enable, [1] underrun interrupt enable |
| uf_clr | input | 1 | Write-one pulse clearing the underrun flag |
| dat_we | input | 1 | Data word write strobe |
| dat_wdata | input | 32 | Data word |
| slot_req | input | 1 | Serializer asks for the sample of slot_id |
| slot_id | input | 4 | Slot number being requested |
| out_valid | output | 1 | Sample for a served slot present |
| out_slot | output | 4 | Slot number of the presented sample |
| out_data | output | 20 | MSB-justified slot value |
| st_busy | output | 1 | Transmit busy |
| st_empty | output | 1 | FIFO empty |
| st_half_empty | output | 1 | FIFO at least half empty |
| st_full | output | 1 | FIFO full |
| st_underrun | output | 1 | Sticky underrun flag |
| irq_tx | output | 1 | Half-empty interrupt |
| irq_uf | output | 1 | Underrun interrupt |

## Verification
Two pairs of events can land in the same cycle.

The first pair is a data write and a slot service. The stimulus writes words on the same cycles the serializer requests enabled slots, both with the FIFO full and with it empty. In those cycles the stored count and the full flag are compared against a reference queue. That reference queue pops before it pushes, and it drops any write made while full.

The second pair is an underrun and its clear pulse. The random stimulus issues uf_clr on the cycle an enabled slot is served from an empty FIFO. After such a cycle the sticky flag is expected to stay high.

// File: rtl/pcmtx_pkg.sv
package pcmtx_pkg;

  localparam int SLOT_LO = 3;
  localparam int N_SLOTS = 7;
  localparam int SLOT_DW = 20;
  localparam int WORD_W  = 32;
  localparam int CTRL_W  = 12;

  typedef enum logic [1:0] {
    SZ_16 = 2'd0,
    SZ_18 = 2'd1,
    SZ_20 = 2'd2,
    SZ_12 = 2'd3
  } samp_size_e;

  typedef struct packed {
    logic [N_SLOTS-1:0] slot_mask;
    logic               compact;
    samp_size_e         size;
    logic               fifo_en;
    logic               ch_en;
  } ctrl_t;

  function automatic logic [SLOT_DW-1:0] justify(input logic [WORD_W-1:0] w,
                                                 input samp_size_e sz);
    logic [SLOT_DW-1:0] r;
    unique case (sz)
      SZ_16:   r = {w[15:0], 4'h0};
      SZ_18:   r = {w[17:0], 2'b00};
      SZ_20:   r = w[19:0];
      default: r = {w[11:0], 8'h00};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pcmtx_fifo.sv
module pcmtx_fifo #(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              fifo_en,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              pop,
  output logic [WORD_W-1:0] head,
  output logic              empty,
  output logic              full,
  output logic              half_empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PW-1:0] rd_q, rd_n, wr_q, wr_n;
  logic [CW-1:0] lvl_q, lvl_n;
  logic [CW:0]   cap, lvl_x2;
  logic          push, take;

  assign cap        = fifo_en ? (CW+1)'(DEPTH) : (CW+1)'(1);
  assign lvl_x2     = {lvl_q, 1'b0};
  assign empty      = (lvl_q == '0);
  assign full       = ({1'b0, lvl_q} >= cap);
  assign half_empty = (lvl_x2 <= cap);
  assign head       = mem[rd_q];

  assign push = wr & ~full & ~flush;
  assign take = pop & ~empty & ~flush;

  always_comb begin
    rd_n  = rd_q;
    wr_n  = wr_q;
    lvl_n = lvl_q;
    if (flush) begin
      rd_n  = '0;
      wr_n  = '0;
      lvl_n = '0;
    end else begin
      if (take) rd_n = (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
      if (push) wr_n = (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
      unique case ({push, take})
        2'b10:   lvl_n = lvl_q + 1'b1;
        2'b01:   lvl_n = lvl_q - 1'b1;
        default: lvl_n = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      lvl_q <= '0;
    end else begin
      rd_q  <= rd_n;
      wr_q  <= wr_n;
      lvl_q <= lvl_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= wdata;
  end

endmodule

// File: rtl/pcmtx_unpack.sv
module pcmtx_unpack
  import pcmtx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               serve,
  input  logic               compact,
  input  samp_size_e         size,
  input  logic [WORD_W-1:0]  head,
  input  logic               empty,
  output logic               pop,
  output logic               starve,
  output logic [SLOT_DW-1:0] sample
);
  logic half_hi_q, half_hi_n;
  logic [15:0] half_word;

  assign half_word = half_hi_q ? head[31:16] : head[15:0];
  assign starve    = serve & empty;
  assign pop       = serve & ~empty & (~compact | half_hi_q);

  always_comb begin
    if (empty)        sample = '0;
    else if (compact) sample = {half_word, 4'h0};
    else              sample = justify(head, size);
  end

  always_comb begin
    half_hi_n = half_hi_q;
    if (flush)                half_hi_n = 1'b0;
    else if (serve && !empty) half_hi_n = compact ? ~half_hi_q : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_hi_q <= 1'b0;
    else        half_hi_q <= half_hi_n;
  end

endmodule

// File: rtl/pcmtx_irq.sv
module pcmtx_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ie_we,
  input  logic [1:0] ie_wdata,
  input  logic       starve,
  input  logic       uf_clr,
  input  logic       half_empty,
  input  logic       ch_en,
  output logic       underrun,
  output logic       irq_tx,
  output logic       irq_uf
);
  logic [1:0] ie_q, ie_n;
  logic       uf_q, uf_n;

  always_comb begin
    ie_n = ie_we ? ie_wdata : ie_q;
    if (starve)      uf_n = 1'b1;
    else if (uf_clr) uf_n = 1'b0;
    else             uf_n = uf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q <= '0;
      uf_q <= 1'b0;
    end else begin
      ie_q <= ie_n;
      uf_q <= uf_n;
    end
  end

  assign underrun = uf_q;
  assign irq_tx   = ie_q[0] & half_empty & ch_en;
  assign irq_uf   = ie_q[1] & uf_q;

endmodule

// File: rtl/pcm_tx_channel.sv
module pcm_tx_channel
  import pcmtx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               link_en,
  input  logic               ctrl_we,
  input  logic [CTRL_W-1:0]  ctrl_wdata,
  input  logic               ie_we,
  input  logic [1:0]         ie_wdata,
  input  logic               uf_clr,
  input  logic               dat_we,
  input  logic [WORD_W-1:0]  dat_wdata,
  input  logic               slot_req,
  input  logic [3:0]         slot_id,
  output logic               out_valid,
  output logic [3:0]         out_slot,
  output logic [SLOT_DW-1:0] out_data,
  output logic               st_busy,
  output logic               st_empty,
  output logic               st_half_empty,
  output logic               st_full,
  output logic               st_underrun,
  output logic               irq_tx,
  output logic               irq_uf
);
  ctrl_t ctrl_q, ctrl_n;
  logic [N_SLOTS-1:0] slot_hit;
  logic serve, flush, pop, starve;
  logic [WORD_W-1:0]  head;
  logic [SLOT_DW-1:0] sample;
  logic               ov_n;
  logic [3:0]         oslot_n;
  logic [SLOT_DW-1:0] odata_n;

  assign ctrl_n = ctrl_we ? ctrl_t'(ctrl_wdata) : ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_n;
  end

  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    assign slot_hit[g] = ctrl_q.slot_mask[g] && (slot_id == 4'(SLOT_LO + g));
  end

  assign flush = ~link_en;
  assign serve = slot_req & link_en & ctrl_q.ch_en & (|slot_hit);

  pcmtx_fifo #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .fifo_en    (ctrl_q.fifo_en),
    .wr         (dat_we),
    .wdata      (dat_wdata),
    .pop        (pop),
    .head       (head),
    .empty      (st_empty),
    .full       (st_full),
    .half_empty (st_half_empty)
  );

  pcmtx_unpack u_unpack (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .serve   (serve),
    .compact (ctrl_q.compact),
    .size    (ctrl_q.size),
    .head    (head),
    .empty   (st_empty),
    .pop     (pop),
    .starve  (starve),
    .sample  (sample)
  );

  pcmtx_irq u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ie_we      (ie_we),
    .ie_wdata   (ie_wdata),
    .starve     (starve),
    .uf_clr     (uf_clr),
    .half_empty (st_half_empty),
    .ch_en      (ctrl_q.ch_en),
    .underrun   (st_underrun),
    .irq_tx     (irq_tx),
    .irq_uf     (irq_uf)
  );

  always_comb begin
    ov_n    = serve;
    oslot_n = serve ? slot_id : out_slot;
    odata_n = serve ? sample  : out_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_slot  <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= ov_n;
      out_slot  <= oslot_n;
      out_data  <= odata_n;
    end
  end

  assign st_busy = (ctrl_q.ch_en & ~st_empty) | out_valid;

endmodule

// File: rtl/pcmtx_chk.sv
module pcmtx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       link_en,
  input logic       ctrl_we,
  input logic       dat_we,
  input logic       uf_clr,
  input logic       serve,
  input logic       out_valid,
  input logic [3:0] out_slot,
  input logic       st_busy,
  input logic       st_empty,
  input logic       st_half_empty,
  input logic       st_full,
  input logic       st_underrun,
  input logic       irq_tx
);
  // R2
  write_full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_full && dat_we && !serve && link_en && !ctrl_we) |=> st_full);
  // R4
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_full && st_empty));
  // R4
  empty_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_empty |-> st_half_empty);
  // R5
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_empty && !out_valid) |-> !st_busy);
  // R8
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_slot >= 4'd3 && out_slot <= 4'd9));
  // R9
  uf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (serve && st_empty) |=> st_underrun);
  // R10
  uf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_underrun && !uf_clr) |=> st_underrun);
  // R11
  irq_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx |-> st_half_empty);
  // R12
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !link_en |=> st_empty);
  // R13
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    serve |=> out_valid);
  // R13
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !serve |=> !out_valid);
endmodule

bind pcm_tx_channel pcmtx_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .link_en       (link_en),
  .ctrl_we       (ctrl_we),
  .dat_we        (dat_we),
  .uf_clr        (uf_clr),
  .serve         (serve),
  .out_valid     (out_valid),
  .out_slot      (out_slot),
  .st_busy       (st_busy),
  .st_empty      (st_empty),
  .st_half_empty (st_half_empty),
  .st_full       (st_full),
  .st_underrun   (st_underrun),
  .irq_tx        (irq_tx)
);

// File: tb/tb_pcm_tx_channel.sv
module tb_pcm_tx_channel;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_en = 1'b1, ctrl_we = 1'b0, ie_we = 1'b0, uf_clr = 1'b0, dat_we = 1'b0, slot_req = 1'b0;
  logic [11:0] ctrl_wdata = '0;
  logic [1:0]  ie_wdata = '0;
  logic [31:0] dat_wdata = '0;
  logic [3:0]  slot_id = '0;
  logic out_valid, st_busy, st_empty, st_half_empty, st_full, st_underrun, irq_tx, irq_uf;
  logic [3:0]  out_slot;
  logic [19:0] out_data;

  int checks = 0;
  int fails  = 0;

  // reference state
  logic [31:0] m_q[$];
  logic [11:0] m_ctrl = '0;
  logic [1:0]  m_ie = '0;
  logic m_half = 1'b0, m_uf = 1'b0, m_ov = 1'b0, m_cmp_at = 1'b0;
  logic [3:0]  m_slot = '0;
  logic [19:0] m_data = '0;

  always #(PERIOD/2) clk = ~clk;

  pcm_tx_channel #(.DEPTH(DEPTH)) dut (.*);

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [19:0] fmt(input logic [31:0] w, input logic [1:0] sz);
    case (sz)
      2'd0: return {w[15:0], 4'h0};
      2'd1: return {w[17:0], 2'b0};
      2'd2: return w[19:0];
      default: return {w[11:0], 8'h0};
    endcase
  endfunction

  function automatic int cap_of(input logic [11:0] c);
    return c[1] ? DEPTH : 1;
  endfunction

  task automatic model_eval();
    int  cap = cap_of(m_ctrl);
    int  n = m_q.size();
    bit  full_b = (n >= cap);
    bit  empty_b = (n == 0);
    bit  hit = (slot_id >= 3 && slot_id <= 9) && m_ctrl[5 + slot_id - 3];
    bit  serve = slot_req && link_en && m_ctrl[0] && hit;
    m_ov = serve;
    if (serve) begin
      m_slot = slot_id;
      m_cmp_at = m_ctrl[4];
    end
    if (!link_en) begin
      m_q.delete();
      m_half = 1'b0;
    end else begin
      if (serve) begin
        if (!empty_b) begin
          logic [31:0] w = m_q[0];
          if (m_ctrl[4]) m_data = {(m_half ? w[31:16] : w[15:0]), 4'h0};
          else           m_data = fmt(w, m_ctrl[3:2]);
          if (!m_ctrl[4] || m_half) void'(m_q.pop_front());
          m_half = m_ctrl[4] ? !m_half : 1'b0;
        end else begin
          m_data = '0;
        end
      end
      if (dat_we && !full_b) m_q.push_back(dat_wdata);
    end
    if (serve && empty_b) m_uf = 1'b1;
    else if (uf_clr)      m_uf = 1'b0;
    if (ctrl_we) m_ctrl = ctrl_wdata;
    if (ie_we)   m_ie = ie_wdata;
  endtask

  task automatic compare();
    int  n = m_q.size();
    int  cap = cap_of(m_ctrl);
    bit  he = (2 * n <= cap);
    chk("R13 R8", "out_valid", out_valid, m_ov);
    if (m_ov) begin
      chk("R8", "out_slot", out_slot, m_slot);
      chk(m_cmp_at ? "R7" : "R6", "out_data", out_data, m_data);
    end
    chk("R4", "empty", st_empty, n == 0);
    chk("R4 R2 R3", "full", st_full, n >= cap);
    chk("R4", "half_empty", st_half_empty, he);
    chk("R5", "busy", st_busy, (m_ctrl[0] && n != 0) || m_ov);
    chk("R9", "underrun", st_underrun, m_uf);
    chk("R11", "irq_tx", irq_tx, m_ie[0] && he && m_ctrl[0]);
    chk("R11", "irq_uf", irq_uf, m_ie[1] && m_uf);
  endtask

  task automatic step();
    model_eval();
    @(posedge clk);
    @(negedge clk);
    compare();
    ctrl_we = 0; ie_we = 0; uf_clr = 0; dat_we = 0; slot_req = 0; link_en = 1;
  endtask

  task automatic wr_ctrl(input logic [6:0] mask, input bit cmp, input logic [1:0] sz, input bit fen, input bit en);
    ctrl_we = 1; ctrl_wdata = {mask, cmp, sz, fen, en};
    step();
  endtask

  task automatic push(input logic [31:0] w);
    dat_we = 1; dat_wdata = w;
    step();
  endtask

  task automatic req(input int id);
    slot_req = 1; slot_id = 4'(id);
    step();
  endtask

  initial begin : watchdog
    #(PERIOD * 200000);
    fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "empty", st_empty, 1);
    chk("R1", "half_empty", st_half_empty, 1);
    chk("R1", "full", st_full, 0);
    chk("R1", "busy", st_busy, 0);
    chk("R1", "underrun", st_underrun, 0);
    chk("R1", "irqs", {irq_tx, irq_uf}, 0);
    chk("R1", "out_valid", out_valid, 0);

    ie_we = 1; ie_wdata = 2'b11; step();
    // R2: fill beyond capacity, extra words dropped
    wr_ctrl(7'h7f, 0, 2'd0, 1, 1);
    for (int i = 0; i < DEPTH + 2; i++) push(32'h1000 + i);
    chk("R2", "full after overfill", st_full, 1);
    for (int i = 0; i < DEPTH + 2; i++) req(3 + (i % 7));
    // R9 underrun, then R10 clear
    chk("R9", "underrun after drain", st_underrun, 1);
    uf_clr = 1; step();
    chk("R10", "underrun cleared", st_underrun, 0);
    // R9 set wins over clear
    slot_req = 1; slot_id = 4; uf_clr = 1; step();
    chk("R9", "set beats clear", st_underrun, 1);
    uf_clr = 1; step();

    // R3: FIFO disabled, capacity one word
    wr_ctrl(7'h7f, 0, 2'd0, 0, 1);
    push(32'hAAAA_0001);
    chk("R3", "full at one word", st_full, 1);
    push(32'hAAAA_0002);
    req(3);
    chk("R3", "second word dropped", out_data, {16'h0001, 4'h0});
    req(4);
    chk("R3", "empty after one", st_underrun, 1);
    uf_clr = 1; step();

    // R7: compact, slots 3,4,6,7,8,9
    wr_ctrl(7'b1111011, 1, 2'd0, 1, 1);
    push(32'h2222_1111); push(32'h4444_3333); push(32'h6666_5555);
    for (int s = 3; s <= 9; s++) req(s);
    chk("R7", "LFE slot gets last upper half", out_data, {16'h6666, 4'h0});
    chk("R8", "last slot", out_slot, 9);

    // R12: disable keeps contents and half pointer
    push(32'hBBBB_AAAA);
    req(3);
    wr_ctrl(7'b1111011, 1, 2'd0, 1, 0);
    req(4);
    chk("R12", "no service while disabled", out_valid, 0);
    chk("R12", "contents kept", st_empty, 0);
    wr_ctrl(7'b1111011, 1, 2'd0, 1, 1);
    req(4);
    chk("R12", "resume upper half", out_data, {16'hBBBB, 4'h0});
    push(32'hDDDD_CCCC); req(3);
    link_en = 0; step();
    chk("R12", "flush empties", st_empty, 1);
    push(32'hFFFF_EEEE); req(4);
    chk("R12", "pairing restarts low", out_data, {16'hEEEE, 4'h0});

    // R6: every size code
    for (int sz = 0; sz < 4; sz++) begin
      wr_ctrl(7'h7f, 0, 2'(sz), 1, 1);
      push(32'h9ABC_DEF5);
      req(5);
    end
    // R8: masked / out-of-range slots ignored
    wr_ctrl(7'b0000001, 0, 2'd0, 1, 1);
    push(32'h0000_1234);
    req(4); req(10); req(2);
    chk("R8", "word not consumed", st_empty, 0);
    req(3);

    // random phase
    for (int cyc = 0; cyc < 4000; cyc++) begin
      int sl = 3 + (cyc % 7);
      if ($urandom_range(0, 31) == 0) begin
        ctrl_we = 1;
        ctrl_wdata = {7'($urandom()), 1'($urandom()), 2'($urandom()),
                      ($urandom_range(0, 7) != 0), ($urandom_range(0, 7) != 0)};
      end
      if ($urandom_range(0, 15) == 0) begin ie_we = 1; ie_wdata = 2'($urandom()); end
      link_en  = ($urandom_range(0, 127) != 0);
      uf_clr   = ($urandom_range(0, 7) == 0);
      dat_we   = $urandom_range(0, 1);
      dat_wdata = $urandom();
      slot_req = ($urandom_range(0, 2) != 0);
      slot_id  = ($urandom_range(0, 9) == 0) ? 4'($urandom()) : 4'(sl);
      step();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule